// File: doc/BRIEF.md
# Foldable Two-Partition Scan Wrapper

This block wraps one embedded core whose scan flip-flops are divided into two partitions of equal length. It can fold both partitions into one serial chain fed from a single test-access wire, or run them side by side as two chains fed from two wires. Each partition has its own shift clock enable. In folded mode only one partition shifts at a time, which halves the switching activity during shift. In parallel mode both partitions shift together, which halves the shift time.

A test controller selects the mode, gives the number of vectors to apply and pulses `start`. An internal sequencer then runs every shift pass and capture cycle. Loading the next vector overlaps with unloading the previous response. The controller drives stimulus bits and samples response bits on the wires in a fixed order. `done` marks the end of the run. The flip-flop contents are visible to the core on `core_stim`, and the core returns its response on `core_resp`.

Top module: `scan_fold_wrapper`

## Requirements
- R1: After reset, `done`, `scan_en`, `part_en`, `tam_out0` and `tam_out1` are 0, and `core_stim` is all zero.
- R2: With N vectors and partition length L, `done` rises exactly (N+1)·P + N cycles after the clock edge that samples `start` in idle. P is 2L in folded mode (`wide_mode`=0) and L in parallel mode (`wide_mode`=1).
- R3: `scan_en` is 1 in every cycle of a shift pass. Between two passes it is 0 for exactly one capture cycle. `done` is 1 for one cycle right after the final pass, and the block is then idle.
- R4: In folded mode, the bit driven on `tam_in0` in cycle j (0-based) of a shift pass ends up in `core_stim[j]`. Bits 0 to L-1 form partition 0 and bits L to 2L-1 form partition 1.
- R5: In folded mode, `part_en` is 2'b01 during the first L cycles of a pass and 2'b10 during the last L cycles. At no time is more than one bit set.
- R6: In parallel mode, `part_en` is 2'b11 for all L cycles of a pass. The bit on `tam_in0` in cycle i lands in `core_stim[i]`, and the bit on `tam_in1` lands in `core_stim[L+i]`.
- R7: In the capture cycle, `core_resp` is loaded into the flip-flops, and the next pass unloads it. In folded mode, `tam_out0` in cycle j shows response bit j and `tam_out1` stays 0. In parallel mode, in cycle i, `tam_out0` shows bit i and `tam_out1` shows bit L+i.
- R8: Outside shift passes (idle, capture, done), `part_en` is 2'b00 and both TAM outputs are 0.
- R9: The mode and the vector count are taken only when `start` is sampled in idle. Changes on `wide_mode`, `vec_count` or `start` during a run do not alter its timing, enables or data routing.
- R10: A vector count of 0 gives one shift pass with no capture cycle, followed by `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when sampled in idle |
| wide_mode | input | 1 | 0 = folded single chain, 1 = two parallel chains |
| vec_count | input | CNT_W | Number of vectors to apply |
| tam_in0 | input | 1 | Test-access input wire 0 |
| tam_in1 | input | 1 | Test-access input wire 1 (parallel mode only) |
| core_resp | input | 2*PART_LEN | Core response captured into the flip-flops |
| tam_out0 | output | 1 | Test-access output wire 0 |
| tam_out1 | output | 1 | Test-access output wire 1 (parallel mode only) |
| part_en | output | 2 | Shift clock enable per partition |
| scan_en | output | 1 | High while shifting, low in capture |
| done | output | 1 | One-cycle end-of-run pulse |
| core_stim | output | 2*PART_LEN | Present flip-flop contents driven into the core |

## Verification
The bench builds the wrapper with PART_LEN=5, an odd length that makes the folded handover fall at a non-power-of-two cycle. It also sets CNT_W=4, so the largest vector count of 15 lies within a short run. With these values, every cycle of every pass can be checked bit by bit in both modes, together with the zero-vector case and runs whose mode and count inputs are disturbed mid-run.

// File: rtl/scan_fold_wrapper.sv
module scan_fold_wrapper #(
  parameter int PART_LEN = 8,
  parameter int CNT_W    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  wide_mode,
  input  logic [CNT_W-1:0]      vec_count,
  input  logic                  tam_in0,
  input  logic                  tam_in1,
  input  logic [2*PART_LEN-1:0] core_resp,
  output logic                  tam_out0,
  output logic                  tam_out1,
  output logic [1:0]            part_en,
  output logic                  scan_en,
  output logic                  done,
  output logic [2*PART_LEN-1:0] core_stim
);
  localparam int POS_W = $clog2(2 * PART_LEN);
  localparam logic [POS_W-1:0] HALF_END = POS_W'(PART_LEN - 1);
  localparam logic [POS_W-1:0] FULL_END = POS_W'(2 * PART_LEN - 1);
  localparam logic [POS_W-1:0] UPPER    = POS_W'(PART_LEN);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_CAPT, S_DONE} st_t;

  st_t                 st;
  logic                wide_q;
  logic [CNT_W-1:0]    tv_q;
  logic [CNT_W-1:0]    cap_cnt;
  logic [POS_W-1:0]    pos;
  logic [PART_LEN-1:0] seg0;
  logic [PART_LEN-1:0] seg1;

  logic in_shift, in_capt, upper, pass_end, feed1;

  assign in_shift = (st == S_SHIFT);
  assign in_capt  = (st == S_CAPT);
  assign upper    = (pos >= UPPER);
  assign pass_end = (pos == (wide_q ? HALF_END : FULL_END));
  assign feed1    = wide_q ? tam_in1 : tam_in0;

  assign part_en[0] = in_shift && (wide_q || !upper);
  assign part_en[1] = in_shift && (wide_q || upper);
  assign scan_en    = in_shift;
  assign done       = (st == S_DONE);
  assign core_stim  = {seg1, seg0};

  assign tam_out0 = in_shift && ((!wide_q && upper) ? seg1[0] : seg0[0]);
  assign tam_out1 = in_shift && wide_q && seg1[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      wide_q  <= 1'b0;
      tv_q    <= '0;
      cap_cnt <= '0;
      pos     <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          wide_q  <= wide_mode;
          tv_q    <= vec_count;
          cap_cnt <= '0;
          pos     <= '0;
          st      <= S_SHIFT;
        end
        S_SHIFT: if (pass_end) begin
          pos <= '0;
          st  <= (cap_cnt == tv_q) ? S_DONE : S_CAPT;
        end else begin
          pos <= pos + POS_W'(1);
        end
        S_CAPT: begin
          cap_cnt <= cap_cnt + CNT_W'(1);
          st      <= S_SHIFT;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg0 <= '0;
      seg1 <= '0;
    end else if (in_capt) begin
      seg0 <= core_resp[PART_LEN-1:0];
      seg1 <= core_resp[2*PART_LEN-1:PART_LEN];
    end else begin
      if (part_en[0]) seg0 <= {tam_in0, seg0[PART_LEN-1:1]};
      if (part_en[1]) seg1 <= {feed1, seg1[PART_LEN-1:1]};
    end
  end
endmodule

// File: rtl/scan_fold_wrapper_chk.sv
module scan_fold_wrapper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scan_en,
  input logic       done,
  input logic [1:0] part_en,
  input logic       wide_q
);
  assert_narrow_one_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_q |-> ($countones(part_en) <= 1));

  assert_wide_both_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_q && scan_en) |-> (part_en == 2'b11));

  assert_en_only_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (part_en != 2'b00) |-> scan_en);

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_capture_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scan_en) && !done) |=> scan_en);

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!scan_en && part_en == 2'b00));

  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && $past(scan_en)) |-> $stable(wide_q));

  assert_mode_hold_capt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !done && $past(scan_en)) |-> $stable(wide_q));
endmodule

bind scan_fold_wrapper scan_fold_wrapper_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scan_en (scan_en),
  .done    (done),
  .part_en (part_en),
  .wide_q  (wide_q)
);

// File: tb/sim_scan_fold_wrapper.sv
module sim_scan_fold_wrapper;
  localparam int PL = 5;
  localparam int NB = 2 * PL;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic wide_mode = 1'b0;
  logic [CW-1:0] vec_count = '0;
  logic tam_in0 = 1'b0;
  logic tam_in1 = 1'b0;
  logic [NB-1:0] core_resp = '0;
  logic tam_out0, tam_out1, scan_en, done;
  logic [1:0] part_en;
  logic [NB-1:0] core_stim;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  scan_fold_wrapper #(.PART_LEN(PL), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .wide_mode(wide_mode),
    .vec_count(vec_count), .tam_in0(tam_in0), .tam_in1(tam_in1),
    .core_resp(core_resp), .tam_out0(tam_out0), .tam_out1(tam_out1),
    .part_en(part_en), .scan_en(scan_en), .done(done), .core_stim(core_stim)
  );

  function automatic int exp_cycles(input bit w, input int tv);
    int p = w ? PL : 2 * PL;
    return (tv + 1) * p + tv;
  endfunction

  function automatic logic [1:0] exp_en(input bit w, input int c);
    if (w) return 2'b11;
    return (c < PL) ? 2'b01 : 2'b10;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_test(input bit w, input int tv, input bit disturb);
    int len = w ? PL : 2 * PL;
    int cyc = 0;
    logic [NB-1:0] vec = '0;
    logic [NB-1:0] resp = '0;
    bit have_resp = 1'b0;
    string tag_t = disturb ? "R9" : (tv == 0 ? "R10" : "R2");
    @(negedge clk);
    wide_mode = w; vec_count = CW'(tv); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      wide_mode = !w;
      vec_count = CW'($urandom);
    end
    for (int p = 0; p <= tv; p++) begin
      vec = '0;
      for (int c = 0; c < len; c++) begin
        logic a, b;
        a = 1'($urandom); b = 1'($urandom);
        tam_in0 = a; tam_in1 = b;
        if (w) begin vec[c] = a; vec[PL + c] = b; end
        else vec[c] = a;
        check(scan_en === 1'b1 && done === 1'b0, "R3", "shift scan_en/done",
              {30'd0, scan_en, done}, 32'd2);
        check(part_en === exp_en(w, c), w ? "R6" : "R5", "part_en in shift",
              {30'd0, part_en}, {30'd0, exp_en(w, c)});
        if (have_resp) begin
          logic e0, e1;
          e0 = resp[c];
          e1 = w ? resp[PL + c] : 1'b0;
          check(tam_out0 === e0 && tam_out1 === e1, "R7", "unload bits",
                {30'd0, tam_out1, tam_out0}, {30'd0, e1, e0});
        end
        start = (disturb && p == 0 && c == 1);
        @(negedge clk);
        cyc++;
      end
      start = 1'b0;
      if (p < tv) begin
        check(scan_en === 1'b0 && part_en === 2'b00 && tam_out0 === 1'b0 && tam_out1 === 1'b0,
              "R8", "capture quiet", {28'd0, scan_en, part_en, tam_out0}, 32'd0);
        check(core_stim === vec, w ? "R6" : "R4", "loaded vector",
              {22'd0, core_stim}, {22'd0, vec});
        resp = NB'($urandom);
        core_resp = resp;
        have_resp = 1'b1;
        @(negedge clk);
        cyc++;
        check(scan_en === 1'b1, "R3", "single capture cycle", {31'd0, scan_en}, 32'd1);
      end
    end
    check(done === 1'b1 && cyc == exp_cycles(w, tv), tag_t, "done timing",
          {31'd0, done}, 32'd1);
    check(core_stim === vec, tv == 0 ? "R10" : (w ? "R6" : "R4"), "final vector",
          {22'd0, core_stim}, {22'd0, vec});
    @(negedge clk);
    check(done === 1'b0 && scan_en === 1'b0 && part_en === 2'b00 && tam_out0 === 1'b0,
          "R3", "idle after done", {28'd0, done, scan_en, part_en}, 32'd0);
    check(tam_out1 === 1'b0, "R8", "idle out1", {31'd0, tam_out1}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(done === 1'b0 && scan_en === 1'b0 && part_en === 2'b00, "R1",
          "reset controls", {28'd0, done, scan_en, part_en}, 32'd0);
    check(tam_out0 === 1'b0 && tam_out1 === 1'b0 && core_stim === '0, "R1",
          "reset data", {21'd0, core_stim, tam_out0}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done === 1'b0 && scan_en === 1'b0, "R1", "idle after release",
          {30'd0, done, scan_en}, 32'd0);

    run_test(1'b0, 0, 1'b0);
    run_test(1'b1, 0, 1'b0);
    run_test(1'b0, 1, 1'b0);
    run_test(1'b1, 3, 1'b0);
    run_test(1'b0, 15, 1'b0);
    run_test(1'b1, 15, 1'b0);
    run_test(1'b0, 2, 1'b1);
    run_test(1'b1, 2, 1'b1);
    for (int k = 0; k < 10; k++)
      run_test(1'($urandom), int'($urandom % 6), 1'($urandom));

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule